// File: doc/BRIEF.md
# Resizable Partitioned Circular Entry Buffer

This block keeps the ordering state of a circular in-order buffer, such as a reorder buffer, whose storage is cut into equal partitions that can each be switched on or off. Entries are taken at the tail and released at the head, strictly in order. The number of live partitions is always a prefix starting at partition 0. The ring wraps at the end of the last live partition, so its usable length changes with the number of live partitions.

A separate policy unit asks the block to grow or shrink by one partition. A grow adds the next partition above the live ones. It is applied only when the occupied region does not wrap; otherwise it waits. A shrink condemns the highest live partition. From then on, no new entry lands in that partition. Its enable bit drops only once every entry inside it has been committed. This can hold allocation off for a long time, because the ring must drain in order.

Payload storage, flush and the choice of when to resize belong to the surrounding logic. The block provides the entry indices (`tail_idx`, `head_idx`), the power-enable mask and the occupancy status.

Top module: `pcb_resizable_ring`

## Requirements
- R1: After reset all partitions are live, occupancy is 0, `empty` is 1, `full` is 0, both pointers are 0 and neither pending flag is set.
- R2: Allocation and commit may happen in the same cycle. `occupancy` changes by the accepted allocations minus the accepted commits.
- R3: `full` is 1 exactly when occupancy equals the live capacity (live partitions times partition depth), and no allocation is accepted while full. `empty` is 1 exactly when occupancy is 0, and no commit is accepted while empty.
- R4: Each accepted allocation moves `tail_idx` by one and each accepted commit moves `head_idx` by one. Both wrap from live capacity minus one to 0.
- R5: A shrink request accepted with no resize pending and more than one live partition raises `shrink_pending`, which condemns the highest live partition. Shrink requests are ignored otherwise. A grow request wins when both requests arrive in a cycle where the grow can be accepted.
- R6: While `shrink_pending` is 1, no allocation is accepted when `tail_idx` lies in the condemned partition.
- R7: The condemned partition's bit of `part_active` (bit i enables partition i) clears only in a cycle after its last entry has been committed. At that point `shrink_pending` clears. A non-empty ring whose tail sat at the condemned partition's first index continues at index 0. An empty ring has both pointers set to 0.
- R8: A grow request accepted with fewer than all partitions live raises `grow_pending`. The request is ignored when all partitions are live. The grow is applied when the ring is empty, when head < tail, or when tail is 0. A non-empty ring with tail 0 then continues at the old capacity. An empty ring has both pointers set to 0. Otherwise the grow stays pending.
- R9: In the cycle a grow or shrink is applied, `alloc_ok` and `commit_ok` are both 0.
- R10: `part_active` is always a contiguous run of ones starting at bit 0, with bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Request to take one entry at the tail |
| commit_req | input | 1 | Request to release the entry at the head |
| grow_req | input | 1 | Request to bring one more partition live |
| shrink_req | input | 1 | Request to retire the highest live partition |
| alloc_ok | output | 1 | Allocation accepted this cycle, entry index is `tail_idx` |
| commit_ok | output | 1 | Commit accepted this cycle, entry index is `head_idx` |
| tail_idx | output | $clog2(NUM_PARTS*PART_DEPTH) | Next entry to allocate |
| head_idx | output | $clog2(NUM_PARTS*PART_DEPTH) | Oldest live entry |
| occupancy | output | $clog2(NUM_PARTS*PART_DEPTH+1) | Entries currently held |
| full | output | 1 | Occupancy equals live capacity |
| empty | output | 1 | No entries held |
| part_active | output | NUM_PARTS | Per-partition power enable |
| shrink_pending | output | 1 | Shrink accepted, condemned partition still draining |
| grow_pending | output | 1 | Grow accepted, waiting for an unwrapped ring |

## Verification
A wrong partition count or a stale per-partition entry tally shows up at the ports as an enable bit that drops while committed work still sits in the partition. It also shows up as a shrink that never completes. Both become visible on `part_active` and `shrink_pending` within one cycle of the head leaving the condemned partition. A pointer wrapped at the wrong boundary shows on `tail_idx` or `head_idx` the first time the ring passes the end of live capacity. It then corrupts `full` one allocation later. The bench keeps a reference model for every entry slot and compares every output in every cycle. A divergence is therefore reported in the cycle it first reaches a port, including the deferred-grow and long-drain cases.

// File: rtl/pcb_pkg.sv
// Shared types for the resizable partitioned ring.
package pcb_pkg;
    // Resize sequencing state: at most one resize is in flight at a time.
    typedef enum logic [1:0] {
        RZ_IDLE   = 2'd0,
        RZ_GROW   = 2'd1,
        RZ_SHRINK = 2'd2
    } rz_state_e;
endpackage

// File: rtl/pcb_ring_ptr.sv
// Circular pointer register.
// Moves by one on adv and wraps to 0 after last_idx. A load takes priority over advance.
// Assumes the caller never loads and advances in the same cycle.
module pcb_ring_ptr #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             ld,
    input  logic [IDX_W-1:0] ld_val,
    output logic [IDX_W-1:0] ptr
);
    // Pointer update: reset, load, or wrapped increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ld) begin
            ptr <= ld_val;
        end else if (adv) begin
            ptr <= (ptr == last_idx) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/pcb_part_counts.sv
// Per-partition count of held entries.
// Increments when an entry is placed into a partition and decrements when one is committed from it.
// Assumes inc_en never fires on a full partition and dec_en never on an empty one.
module pcb_part_counts #(
    parameter int NUM_PARTS = 6,
    parameter int CNT_W     = 5,
    parameter int PART_W    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             inc_en,
    input  logic [PART_W-1:0]                inc_part,
    input  logic                             dec_en,
    input  logic [PART_W-1:0]                dec_part,
    output logic [NUM_PARTS-1:0][CNT_W-1:0]  cnt
);
    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
        logic inc_hit;
        logic dec_hit;
        assign inc_hit = inc_en && (inc_part == PART_W'(p));
        assign dec_hit = dec_en && (dec_part == PART_W'(p));

        // Net count update for this partition.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt[p] <= '0;
            end else begin
                case ({inc_hit, dec_hit})
                    2'b10:   cnt[p] <= cnt[p] + 1'b1;
                    2'b01:   cnt[p] <= cnt[p] - 1'b1;
                    default: cnt[p] <= cnt[p];
                endcase
            end
        end
    end
endmodule

// File: rtl/pcb_resize_ctrl.sv
// Resize sequencer.
// Latches one grow or shrink request, decides in which cycle it may be applied, and holds the live partition count.
// Assumes head/tail/occ_zero describe the current ring and cond_cnt is the count of the highest live partition.
module pcb_resize_ctrl
    import pcb_pkg::*;
#(
    parameter int NUM_PARTS = 6,
    parameter int IDX_W     = 7,
    parameter int CNT_W     = 5,
    parameter int K_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grow_req,
    input  logic             shrink_req,
    input  logic [IDX_W-1:0] head,
    input  logic [IDX_W-1:0] tail,
    input  logic             occ_zero,
    input  logic [CNT_W-1:0] cond_cnt,
    output logic [K_W-1:0]   act_cnt,
    output rz_state_e        rz_state,
    output logic             grow_fire,
    output logic             shrink_fire
);
    logic can_grow;
    logic can_shrink;
    logic unwrapped;

    // The ring is unwrapped when empty, head below tail, or tail parked at 0.
    always_comb begin
        unwrapped   = occ_zero || (head < tail) || (tail == '0);
        grow_fire   = (rz_state == RZ_GROW) && unwrapped;
        shrink_fire = (rz_state == RZ_SHRINK) && (cond_cnt == '0);
        can_grow    = int'(act_cnt) < NUM_PARTS;
        can_shrink  = int'(act_cnt) > 1;
    end

    // Request latching, application and live partition count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rz_state <= RZ_IDLE;
            act_cnt  <= K_W'(NUM_PARTS);
        end else if (grow_fire) begin
            rz_state <= RZ_IDLE;
            act_cnt  <= act_cnt + 1'b1;
        end else if (shrink_fire) begin
            rz_state <= RZ_IDLE;
            act_cnt  <= act_cnt - 1'b1;
        end else if (rz_state == RZ_IDLE) begin
            if (grow_req && can_grow) begin
                rz_state <= RZ_GROW;
            end else if (shrink_req && can_shrink) begin
                rz_state <= RZ_SHRINK;
            end
        end
    end
endmodule

// File: rtl/pcb_resizable_ring.sv
// Partitioned circular buffer control with run-time resizing.
// Tracks head, tail and occupancy over a ring whose length is the live partition count times PART_DEPTH.
// A condemned partition takes no new entries and is powered down only once drained.
// Assumes callers act only on alloc_ok / commit_ok and that payload lives elsewhere.
module pcb_resizable_ring
    import pcb_pkg::*;
#(
    parameter int NUM_PARTS  = 6,
    parameter int PART_DEPTH = 16,
    localparam int TOTAL     = NUM_PARTS * PART_DEPTH,
    localparam int IDX_W     = $clog2(TOTAL),
    localparam int OCC_W     = $clog2(TOTAL + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_req,
    input  logic                 commit_req,
    input  logic                 grow_req,
    input  logic                 shrink_req,
    output logic                 alloc_ok,
    output logic                 commit_ok,
    output logic [IDX_W-1:0]     tail_idx,
    output logic [IDX_W-1:0]     head_idx,
    output logic [OCC_W-1:0]     occupancy,
    output logic                 full,
    output logic                 empty,
    output logic [NUM_PARTS-1:0] part_active,
    output logic                 shrink_pending,
    output logic                 grow_pending
);
    localparam int CNT_W  = $clog2(PART_DEPTH + 1);
    localparam int K_W    = $clog2(NUM_PARTS + 1);
    localparam int PART_W = (NUM_PARTS > 1) ? $clog2(NUM_PARTS) : 1;

    logic [K_W-1:0]                   act_cnt;
    rz_state_e                        rz_state;
    logic                             grow_fire;
    logic                             shrink_fire;
    logic                             resize_fire;
    logic [OCC_W-1:0]                 cap;
    logic [OCC_W-1:0]                 cond_base;
    logic [IDX_W-1:0]                 last_idx;
    logic [PART_W-1:0]                tail_part;
    logic [PART_W-1:0]                head_part;
    logic [PART_W-1:0]                cond_part;
    logic [NUM_PARTS-1:0][CNT_W-1:0]  part_cnt;
    logic                             tail_in_cond;
    logic                             head_ld;
    logic                             tail_ld;
    logic [IDX_W-1:0]                 tail_ld_val;

    // Live capacity, condemned partition base and the partitions the pointers sit in.
    always_comb begin
        cap       = OCC_W'(int'(act_cnt) * PART_DEPTH);
        cond_base = OCC_W'((int'(act_cnt) - 1) * PART_DEPTH);
        last_idx  = IDX_W'(int'(cap) - 1);
        cond_part = PART_W'(int'(act_cnt) - 1);
        tail_part = PART_W'(int'(tail_idx) / PART_DEPTH);
        head_part = PART_W'(int'(head_idx) / PART_DEPTH);
    end

    // Status flags and acceptance of this cycle's requests.
    always_comb begin
        full           = (occupancy == cap);
        empty          = (occupancy == '0);
        shrink_pending = (rz_state == RZ_SHRINK);
        grow_pending   = (rz_state == RZ_GROW);
        resize_fire    = grow_fire || shrink_fire;
        tail_in_cond   = shrink_pending && (OCC_W'(tail_idx) >= cond_base);
        alloc_ok       = alloc_req && !full && !tail_in_cond && !resize_fire;
        commit_ok      = commit_req && !empty && !resize_fire;
    end

    // Pointer repositioning when a resize is applied.
    always_comb begin
        head_ld     = resize_fire && empty;
        tail_ld     = head_ld
                   || (grow_fire && (tail_idx == '0))
                   || (shrink_fire && (OCC_W'(tail_idx) == cond_base));
        tail_ld_val = (grow_fire && !empty) ? IDX_W'(cap) : '0;
    end

    // Occupancy follows the net of accepted allocations and commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occupancy <= '0;
        end else if (alloc_ok && !commit_ok) begin
            occupancy <= occupancy + 1'b1;
        end else if (commit_ok && !alloc_ok) begin
            occupancy <= occupancy - 1'b1;
        end
    end

    pcb_ring_ptr #(.IDX_W(IDX_W)) u_tail (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (alloc_ok),
        .last_idx (last_idx),
        .ld       (tail_ld),
        .ld_val   (tail_ld_val),
        .ptr      (tail_idx)
    );

    pcb_ring_ptr #(.IDX_W(IDX_W)) u_head (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (commit_ok),
        .last_idx (last_idx),
        .ld       (head_ld),
        .ld_val   ('0),
        .ptr      (head_idx)
    );

    pcb_part_counts #(
        .NUM_PARTS (NUM_PARTS),
        .CNT_W     (CNT_W),
        .PART_W    (PART_W)
    ) u_counts (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (alloc_ok),
        .inc_part (tail_part),
        .dec_en   (commit_ok),
        .dec_part (head_part),
        .cnt      (part_cnt)
    );

    pcb_resize_ctrl #(
        .NUM_PARTS (NUM_PARTS),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W),
        .K_W       (K_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .grow_req    (grow_req),
        .shrink_req  (shrink_req),
        .head        (head_idx),
        .tail        (tail_idx),
        .occ_zero    (empty),
        .cond_cnt    (part_cnt[cond_part]),
        .act_cnt     (act_cnt),
        .rz_state    (rz_state),
        .grow_fire   (grow_fire),
        .shrink_fire (shrink_fire)
    );

    // Power enable: partitions below the live count are on.
    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_mask
        assign part_active[p] = (int'(act_cnt) > p);
    end
endmodule

// File: rtl/pcb_resizable_ring_chk.sv
// Port-level property checker for the resizable ring, attached by bind.
// Assumes synchronous active-low reset held from time zero.
module pcb_resizable_ring_chk #(
    parameter int NUM_PARTS  = 6,
    parameter int PART_DEPTH = 16,
    localparam int TOTAL     = NUM_PARTS * PART_DEPTH,
    localparam int IDX_W     = $clog2(TOTAL),
    localparam int OCC_W     = $clog2(TOTAL + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alloc_ok,
    input logic                 commit_ok,
    input logic [IDX_W-1:0]     tail_idx,
    input logic [OCC_W-1:0]     occupancy,
    input logic                 full,
    input logic                 empty,
    input logic [NUM_PARTS-1:0] part_active,
    input logic                 shrink_pending
);
    // R3
    full_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !alloc_ok);

    // R3
    empty_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !commit_ok);

    // R2
    occ_net_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> occupancy == $past(occupancy) + OCC_W'($past(alloc_ok)) - OCC_W'($past(commit_ok)));

    // R6
    cond_alloc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shrink_pending && (int'(tail_idx) >= ($countones(part_active) - 1) * PART_DEPTH)) |-> !alloc_ok);

    // R7
    mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(part_active) < $past($countones(part_active))) |-> $past(shrink_pending));

    // R9
    resize_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (part_active != $past(part_active)) |-> ($past(!alloc_ok) && $past(!commit_ok)));

    // R10
    mask_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        part_active[0] && ((part_active & (part_active + 1'b1)) == '0));
endmodule

bind pcb_resizable_ring pcb_resizable_ring_chk #(
    .NUM_PARTS  (NUM_PARTS),
    .PART_DEPTH (PART_DEPTH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_ok       (alloc_ok),
    .commit_ok      (commit_ok),
    .tail_idx       (tail_idx),
    .occupancy      (occupancy),
    .full           (full),
    .empty          (empty),
    .part_active    (part_active),
    .shrink_pending (shrink_pending)
);

// File: tb/tb_pcb_resizable_ring.sv
`timescale 1ns/1ps
module tb_pcb_resizable_ring;
    localparam int N   = 6;
    localparam int D   = 16;
    localparam int TOT = N * D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_req = 1'b0, commit_req = 1'b0, grow_req = 1'b0, shrink_req = 1'b0;
    logic alloc_ok, commit_ok, full, empty, shrink_pending, grow_pending;
    logic [$clog2(TOT)-1:0]   tail_idx, head_idx;
    logic [$clog2(TOT+1)-1:0] occupancy;
    logic [N-1:0]             part_active;

    always #5 clk = ~clk;

    pcb_resizable_ring #(.NUM_PARTS(N), .PART_DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .commit_req(commit_req),
        .grow_req(grow_req), .shrink_req(shrink_req), .alloc_ok(alloc_ok),
        .commit_ok(commit_ok), .tail_idx(tail_idx), .head_idx(head_idx),
        .occupancy(occupancy), .full(full), .empty(empty), .part_active(part_active),
        .shrink_pending(shrink_pending), .grow_pending(grow_pending)
    );

    int tests = 0;
    int fails = 0;
    // Reference model: live count, pointers, occupancy, resize state (0 idle, 1 grow, 2 shrink), slot validity.
    int mk = N, mhead = 0, mtail = 0, mocc = 0, mst = 0;
    bit mvalid [TOT];

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit cond_busy();
        for (int i = (mk - 1) * D; i < mk * D; i++) if (mvalid[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit grow_ready();
        return (mocc == 0) || (mhead < mtail) || (mtail == 0);
    endfunction

    function automatic int exp_mask();
        return (1 << mk) - 1;
    endfunction

    // One cycle: drive, compare every output with the model, then advance the model.
    task automatic step(bit a, bit c, bit g, bit s);
        bit gf, sf, ea, ec, blk;
        int cap, base;
        @(negedge clk);
        alloc_req = a; commit_req = c; grow_req = g; shrink_req = s;
        #1;
        cap  = mk * D;
        base = (mk - 1) * D;
        gf   = (mst == 1) && grow_ready();
        sf   = (mst == 2) && !cond_busy();
        blk  = (mst == 2) && (mtail >= base);
        ea   = a && (mocc != cap) && !blk && !gf && !sf;
        ec   = c && (mocc != 0) && !gf && !sf;
        chk("R3 full", int'(full), int'(mocc == cap));
        chk("R3 empty", int'(empty), int'(mocc == 0));
        chk("R2 occupancy", int'(occupancy), mocc);
        chk("R4 head_idx", int'(head_idx), mhead);
        chk("R4 tail_idx", int'(tail_idx), mtail);
        chk("R5 R7 R10 part_active", int'(part_active), exp_mask());
        chk("R5 shrink_pending", int'(shrink_pending), int'(mst == 2));
        chk("R8 grow_pending", int'(grow_pending), int'(mst == 1));
        chk("R3 R6 R9 alloc_ok", int'(alloc_ok), int'(ea));
        chk("R3 R9 commit_ok", int'(commit_ok), int'(ec));
        if (ea) begin
            mvalid[mtail] = 1'b1;
            mtail = (mtail == cap - 1) ? 0 : mtail + 1;
            mocc++;
        end
        if (ec) begin
            mvalid[mhead] = 1'b0;
            mhead = (mhead == cap - 1) ? 0 : mhead + 1;
            mocc--;
        end
        if (gf) begin
            if (mocc == 0) begin mhead = 0; mtail = 0; end
            else if (mtail == 0) mtail = cap;
            mk++; mst = 0;
        end else if (sf) begin
            if (mocc == 0) begin mhead = 0; mtail = 0; end
            else if (mtail == base) mtail = 0;
            mk--; mst = 0;
        end else if (mst == 0) begin
            if (g && mk < N) mst = 1;
            else if (s && mk > 1) mst = 2;
        end
    endtask

    task automatic rand_phase(int cycles, int pa, int pc, int pg, int ps);
        for (int i = 0; i < cycles; i++)
            step(($urandom % 100) < pa, ($urandom % 100) < pc,
                 ($urandom % 100) < pg, ($urandom % 100) < ps);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 occupancy", int'(occupancy), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 part_active", int'(part_active), (1 << N) - 1);
        chk("R1 pointers", int'(head_idx) + int'(tail_idx), 0);
        chk("R1 pending", int'(shrink_pending) + int'(grow_pending), 0);

        // R3: fill past capacity, allocation refused when full
        for (int i = 0; i < TOT + 4; i++) step(1, 0, 0, 0);
        // R6 R7: shrink while full at head=tail=0, drain through the condemned partition
        step(0, 0, 0, 1);
        for (int i = 0; i < TOT + 8; i++) step(i % 3 == 0, 1, 0, 0);
        // R8: build a wrapped region, grow deferred until it unwraps
        for (int i = 0; i < 70; i++) step(1, 0, 0, 0);
        for (int i = 0; i < 40; i++) step(0, 1, 0, 0);
        for (int i = 0; i < 30; i++) step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        for (int i = 0; i < 120; i++) step(i % 4 == 0, 1, 0, 0);
        // R5: shrink down to one partition, extra shrinks ignored, then both requests together
        for (int i = 0; i < 10; i++) begin
            step(0, 0, 0, 1);
            for (int j = 0; j < TOT; j++) step(0, 1, 0, 0);
        end
        step(0, 0, 1, 1);
        for (int i = 0; i < 6; i++) step(1, 1, 0, 0);

        // Random mixes: balanced, allocation-heavy, commit-heavy
        rand_phase(3000, 55, 50, 2, 3);
        rand_phase(2000, 85, 30, 3, 3);
        rand_phase(2000, 30, 85, 3, 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule